// File: doc/BRIEF.md
# UART FIFO-Level Interrupt Controller

This block turns the fill levels of a UART's transmit and receive FIFOs into interrupt requests. Software picks a separate threshold for each direction as a fraction of the FIFO depth. The receive request is raised when the receive FIFO fills up to that threshold. The transmit request is raised when the transmit FIFO drains down to its threshold. Each request is latched as a raw status bit. Software clears it by writing a one to the clear register. A mask register selects which raw bits reach the masked status and the single combined interrupt line.

The FIFOs, the shifters and the baud logic sit outside the block. They supply the occupancy counts and the UART and FIFO enable bits. Software reaches the registers through a simple synchronous port. Writes take effect on the clock edge. Read data is the combinational image of the addressed register.

Top module: `uart_lvl_irq`

## Requirements
- R1: After reset, the level-select register reads 0x12, the mask reads 0, the raw status reads 0, `irq_masked` is 0 and `irq` is 0.
- R2: The level-select register is at offset 0x34. Its receive code is in bits [5:3] and its transmit code is in bits [2:0]. The mask is at offset 0x38, with bit 0 for receive and bit 1 for transmit. Bits above those fields read as zero and ignore writes. The raw status reads at 0x3C and the masked status reads at 0x40, both with the same bit order as the mask.
- R3: With a depth of 16, the codes 0, 1, 2, 3 and 4 select thresholds of 2, 4, 8, 12 and 14 entries.
- R4: The reserved codes 5, 6 and 7 select the half-full threshold of 8 entries.
- R5: Raw receive status (bit 0) is set on the clock edge where `rx_level >= threshold` becomes true, and it then stays set.
- R6: Raw transmit status (bit 1) is set on the clock edge where `tx_level <= threshold` becomes true, and it then stays set.
- R7: Writing to offset 0x44 clears each raw bit whose write-data bit is 1. Write-data bits that are 0 leave the raw bits unchanged.
- R8: A set event and a clear of the same bit in the same cycle leave that bit set.
- R9: `irq_masked` is the bitwise AND of raw status and mask.
- R10: `irq` is the OR of the masked bits, registered, so it follows one cycle after a change of raw status or mask.
- R11: While `uart_en` or `fifo_en` is low, no raw bit is set, and the raw bits that are already set are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| uart_en | input | 1 | UART enable bit |
| fifo_en | input | 1 | FIFO enable bit |
| tx_level | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| rx_level | input | 5 | Receive FIFO occupancy, 0 to 16 |
| irq_masked | output | 2 | Masked status, bit 0 for receive and bit 1 for transmit |
| irq | output | 1 | Combined registered interrupt |

## Verification
Two functions can fall in the same cycle: a threshold crossing that sets a raw bit, and a software clear of that bit. The bench provokes the collision by changing the receive occupancy across its threshold on the same edge where the clear register is written with that bit. It then reads the raw status and expects the bit to still be set. The bench also shows that a clear on its own, with no crossing, does remove the bit. This separates the set-wins rule from a clear that is simply ignored.

// File: rtl/uart_lvl_irq_pkg.sv
package uart_lvl_irq_pkg;

    localparam logic [7:0] OFS_LVL = 8'h34;
    localparam logic [7:0] OFS_MSK = 8'h38;
    localparam logic [7:0] OFS_RAW = 8'h3C;
    localparam logic [7:0] OFS_MIS = 8'h40;
    localparam logic [7:0] OFS_CLR = 8'h44;

    localparam int IDX_RX = 0;
    localparam int IDX_TX = 1;

    localparam logic [5:0] LVL_RESET = 6'h12;

    typedef struct packed {
        logic [5:0] lvl;
        logic [1:0] mask;
        logic [1:0] raw;
        logic       irq;
    } ctl_state_t;

    // eighths of the FIFO depth selected by a threshold code
    function automatic int code_eighths(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            3'd4:    return 7;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/uart_lvl_thr.sv
module uart_lvl_thr
    import uart_lvl_irq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic [2:0]       code,
    output logic [CNT_W-1:0] thr
);
    int count;

    always_comb begin
        count = (DEPTH * code_eighths(code)) / 8;
        thr   = CNT_W'(count);
    end
endmodule

// File: rtl/uart_lvl_edge.sv
module uart_lvl_edge #(
    parameter int CNT_W = 5,
    parameter bit IS_RX = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] level,
    input  logic [CNT_W-1:0] thr,
    output logic             set_evt
);
    logic hit;
    logic hit_d, hit_q;

    generate
        if (IS_RX) begin : g_fill
            assign hit = (level >= thr);
        end else begin : g_drain
            assign hit = (level <= thr);
        end
    endgenerate

    always_comb begin
        hit_d   = hit;
        set_evt = en & hit & ~hit_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit_d;
    end
endmodule

// File: rtl/uart_lvl_irq.sv
module uart_lvl_irq
    import uart_lvl_irq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH) + 1,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              uart_en,
    input  logic              fifo_en,
    input  logic [CNT_W-1:0]  tx_level,
    input  logic [CNT_W-1:0]  rx_level,
    output logic [1:0]        irq_masked,
    output logic              irq
);
    localparam int NDIR = 2;

    ctl_state_t st_d, st_q;
    logic [NDIR-1:0] set_vec;
    logic            rx_set, tx_set;
    logic            active;
    logic            unused_wdata;

    assign active       = uart_en & fifo_en;
    assign unused_wdata = ^reg_wdata[DATA_W-1:6];

    generate
        for (genvar d = 0; d < NDIR; d++) begin : g_dir
            logic [2:0]       code;
            logic [CNT_W-1:0] thr;
            logic [CNT_W-1:0] lvl_in;

            if (d == IDX_RX) begin : g_rx
                assign code   = st_q.lvl[5:3];
                assign lvl_in = rx_level;
            end else begin : g_tx
                assign code   = st_q.lvl[2:0];
                assign lvl_in = tx_level;
            end

            uart_lvl_thr #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_thr (
                .code (code),
                .thr  (thr)
            );

            uart_lvl_edge #(.CNT_W(CNT_W), .IS_RX(d == IDX_RX)) u_edge (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (active),
                .level   (lvl_in),
                .thr     (thr),
                .set_evt (set_vec[d])
            );
        end
    endgenerate

    assign rx_set = set_vec[IDX_RX];
    assign tx_set = set_vec[IDX_TX];

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            if (reg_addr == ADDR_W'(OFS_LVL)) st_d.lvl  = reg_wdata[5:0];
            if (reg_addr == ADDR_W'(OFS_MSK)) st_d.mask = reg_wdata[1:0];
            if (reg_addr == ADDR_W'(OFS_CLR)) st_d.raw  = st_q.raw & ~reg_wdata[1:0];
        end
        st_d.raw = st_d.raw | set_vec;
        st_d.irq = |(st_q.raw & st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lvl: LVL_RESET, mask: 2'b00, raw: 2'b00, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFS_LVL): reg_rdata[5:0] = st_q.lvl;
            ADDR_W'(OFS_MSK): reg_rdata[1:0] = st_q.mask;
            ADDR_W'(OFS_RAW): reg_rdata[1:0] = st_q.raw;
            ADDR_W'(OFS_MIS): reg_rdata[1:0] = st_q.raw & st_q.mask;
            default:          reg_rdata      = '0;
        endcase
    end

    assign irq_masked = st_q.raw & st_q.mask;
    assign irq        = st_q.irq;
endmodule

// File: rtl/uart_lvl_irq_chk.sv
module uart_lvl_irq_chk
    import uart_lvl_irq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        uart_en,
    input logic        fifo_en,
    input logic        rx_set,
    input logic        tx_set,
    input logic [1:0]  irq_masked,
    input logic        irq
);
    // R2
    lvl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_LVL) |-> (reg_rdata[31:6] == '0));

    // R5
    rx_set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set |=> (reg_addr != OFS_RAW) || reg_rdata[0]);

    // R6
    tx_set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_set |=> (reg_addr != OFS_RAW) || reg_rdata[1]);

    // R11
    gated_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(uart_en && fifo_en) |-> !(rx_set || tx_set));

    // R10
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (irq == |$past(irq_masked)));

    // R7
    clear_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CLR && reg_wdata[0] && !rx_set) |=> !irq_masked[0]);
endmodule

bind uart_lvl_irq uart_lvl_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .uart_en    (uart_en),
    .fifo_en    (fifo_en),
    .rx_set     (rx_set),
    .tx_set     (tx_set),
    .irq_masked (irq_masked),
    .irq        (irq)
);

// File: tb/sim_uart_lvl_irq.sv
module sim_uart_lvl_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        uart_en = 1'b0;
    logic        fifo_en = 1'b0;
    logic [4:0]  tx_level = 5'd0;
    logic [4:0]  rx_level = 5'd0;
    logic [1:0]  irq_masked;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_lvl_irq u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .uart_en(uart_en),
        .fifo_en(fifo_en), .tx_level(tx_level), .rx_level(rx_level),
        .irq_masked(irq_masked), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    function automatic int exp_thr(input int code);
        case (code)
            0: return 2;
            1: return 4;
            2: return 8;
            3: return 12;
            4: return 14;
            default: return 8;
        endcase
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h34, v); check("R1", "level reset", v, 32'h12);
        rd(8'h38, v); check("R1", "mask reset", v, 0);
        rd(8'h3C, v); check("R1", "raw reset", v, 0);
        check("R1", "irq_masked reset", irq_masked, 0);
        check("R1", "irq reset", irq, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(8'h34, 32'hFFFF_FF2B);
        rd(8'h34, v); check("R2", "level field layout", v, 32'h2B);
        wr(8'h38, 32'hFFFF_FFFE);
        rd(8'h38, v); check("R2", "mask upper bits", v, 32'h2);
        wr(8'h38, 32'h0);
        wr(8'h34, 32'h12);
    endtask

    task automatic t_rx_thr();
        logic [31:0] v;
        for (int c = 0; c < 8; c++) begin
            int t;
            t = exp_thr(c);
            wr(8'h34, 32'(c << 3) | 32'h2);
            rx_level = 5'd0; tick();
            wr(8'h44, 32'h3);
            rx_level = 5'(t - 1); tick();
            rd(8'h3C, v);
            check(c > 4 ? "R4" : "R3", $sformatf("rx below thr code %0d", c), v & 1, 0);
            rx_level = 5'(t); tick();
            rd(8'h3C, v);
            check(c > 4 ? "R4" : "R5", $sformatf("rx at thr code %0d", c), v & 1, 1);
            rx_level = 5'd16; tick();
            rd(8'h3C, v); check("R5", "rx stays set", v & 1, 1);
        end
        rx_level = 5'd0; tick();
        wr(8'h34, 32'h12);
    endtask

    task automatic t_tx_thr();
        logic [31:0] v;
        for (int c = 0; c < 8; c++) begin
            int t;
            t = exp_thr(c);
            wr(8'h34, 32'h10 | 32'(c));
            tx_level = 5'd16; tick();
            wr(8'h44, 32'h3);
            tx_level = 5'(t + 1); tick();
            rd(8'h3C, v);
            check(c > 4 ? "R4" : "R3", $sformatf("tx above thr code %0d", c), (v >> 1) & 1, 0);
            tx_level = 5'(t); tick();
            rd(8'h3C, v);
            check(c > 4 ? "R4" : "R6", $sformatf("tx at thr code %0d", c), (v >> 1) & 1, 1);
            tx_level = 5'd0; tick();
            rd(8'h3C, v); check("R6", "tx stays set", (v >> 1) & 1, 1);
        end
        tx_level = 5'd16; tick();
        wr(8'h44, 32'h3);
        wr(8'h34, 32'h12);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        rx_level = 5'd0; tick();
        rx_level = 5'd8; tx_level = 5'd8; tick();
        rd(8'h3C, v); check("R5", "both set", v, 3);
        wr(8'h44, 32'h0);
        rd(8'h3C, v); check("R7", "zero write keeps", v, 3);
        wr(8'h44, 32'h1);
        rd(8'h3C, v); check("R7", "clear rx only", v, 2);
        wr(8'h44, 32'h2);
        rd(8'h3C, v); check("R7", "clear tx", v, 0);
        tx_level = 5'd16; rx_level = 5'd0; tick();
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(8'h44, 32'h3);
        rx_level = 5'd8;
        wr(8'h44, 32'h1);
        rd(8'h3C, v); check("R8", "set beats clear", v & 1, 1);
        wr(8'h44, 32'h1);
        rd(8'h3C, v); check("R7", "lone clear", v & 1, 0);
        rx_level = 5'd0; tick();
    endtask

    task automatic t_mask_irq();
        logic [31:0] v;
        rx_level = 5'd8; tick();
        check("R9", "masked off", irq_masked, 0);
        check("R10", "irq masked off", irq, 0);
        wr(8'h38, 32'h1);
        check("R9", "masked on", irq_masked, 1);
        rd(8'h40, v); check("R9", "masked read", v, 1);
        check("R10", "irq not yet", irq, 0);
        tick();
        check("R10", "irq after lag", irq, 1);
        wr(8'h44, 32'h1);
        check("R9", "masked after clear", irq_masked, 0);
        check("R10", "irq still high", irq, 1);
        tick();
        check("R10", "irq dropped", irq, 0);
        wr(8'h38, 32'h0);
        rx_level = 5'd0; tick();
    endtask

    task automatic t_gate();
        logic [31:0] v;
        uart_en = 1'b0;
        rx_level = 5'd8; tick();
        rd(8'h3C, v); check("R11", "uart off no set", v & 1, 0);
        rx_level = 5'd0; tick();
        uart_en = 1'b1; fifo_en = 1'b0;
        tx_level = 5'd0; tick();
        rd(8'h3C, v); check("R11", "fifo off no set", (v >> 1) & 1, 0);
        fifo_en = 1'b1;
        rx_level = 5'd8; tick();
        rd(8'h3C, v); check("R5", "enabled sets", v & 1, 1);
        fifo_en = 1'b0;
        rx_level = 5'd0; tick(); tick();
        rd(8'h3C, v); check("R11", "held while off", v & 1, 1);
        fifo_en = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        tx_level = 5'd16; rx_level = 5'd0; tick();
        uart_en = 1'b1; fifo_en = 1'b1; tick();
        t_regs();
        t_rx_thr();
        t_tx_thr();
        t_clear();
        t_collide();
        t_mask_irq();
        t_gate();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule